// File: doc/BRIEF.md
# Reset Sequencer with Handshake Pins

This block is the chip-level reset controller. It runs on the slow sleep clock and gathers four reset sources: a power-on request, an active-high external reset input, a watchdog expiry pulse gated by an enable bit, and a boot-failure request from the internal boot logic. While any reset is being served, it holds the core in reset and forces every ordinary general-purpose pin to high impedance. It also drives two handshake pins through timed drive patterns, so that an external programmer can lock onto the device before firmware starts.

The release sequence depends on the source:

- **Power-on:** two phases of 256 sleep cycles each. In the first, pin A is strong high and pin B is resistive low. In the second, both pins are resistive low.
- **External reset:** both pins drive resistive low while the input is high. They stay resistive low for an 8-cycle tail after the input falls.
- **Watchdog and boot failure:** an 8-cycle core hold with both pins left at high impedance.

A phase code output shows the current step. Sticky cause flags record which reset was taken. Firmware clears them by writing ones. The watchdog enable returns to off whenever any reset is taken.

Top module: `reset_sequencer`

## Requirements
- R1: While in any reset phase (phase code not 0), `core_rst` and `gpio_hiz` are high. After `rst_n` is low at a clock edge, the block is in the first power-on phase with `sts0` = 3'b001, `sts1` = 0 and `wdt_en` = 0.
- R2: After power-on (`rst_n` rising or `por_req` falling), phase code 1 lasts exactly 256 clock edges. During it, `pin_a_mode` = 2'b10 (strong high) and `pin_b_mode` = 2'b01 (resistive low).
- R3: Phase code 2 follows and lasts exactly 256 edges with both pins at 2'b01. After it, both pins are 2'b00 (high impedance) and `core_rst` is low, so release comes 512 edges after the power-on request ends.
- R4: `ext_rst_in` passes through a two-flop synchronizer. While its synchronized value is high, the phase code is 3 and both pins are 2'b01. After it falls, phase code 4 holds both pins at 2'b01 for 8 edges. The core is released on the 11th edge after the input is driven low.
- R5: `wdt_expire` starts a reset only while `wdt_en` is 1, and is otherwise ignored. `wdt_en` is written through `wdt_en_wr`/`wdt_en_wdata` and returns to 0 whenever any reset is taken.
- R6: A watchdog or boot-failure reset enters phase code 5. It holds `core_rst` for 8 edges with both pins at 2'b00.
- R7: `sts0` bit 0 flags power-on, bit 1 flags external reset and bit 2 flags watchdog. `sts1` flags boot failure. Flags stay set through later non-power-on resets.
- R8: Writing 1 to a bit of `sts0_clr` or `sts1_clr` clears that flag and leaves the others alone. A set in the same cycle wins over the clear.
- R9: A power-on reset clears `sts1` and the external and watchdog flags, and sets only the power-on flag.
- R10: Reset requests have the priority power-on, then external, then watchdog, then boot failure. A request taken during a sequence restarts the sequence that matches the winning source.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sleep clock |
| rst_n | input | 1 | Synchronous active-low register reset, treated as power-on |
| por_req | input | 1 | Power-on reset request, level |
| ext_rst_in | input | 1 | External reset pin, active high, asynchronous |
| wdt_expire | input | 1 | Watchdog expiry pulse |
| wdt_en_wr | input | 1 | Write strobe for the watchdog enable |
| wdt_en_wdata | input | 1 | Value written to the watchdog enable |
| boot_fail | input | 1 | Boot-failure reset request |
| sts0_clr | input | 3 | Write-1-to-clear for `sts0` |
| sts1_clr | input | 1 | Write-1-to-clear for `sts1` |
| sts0 | output | 3 | Cause flags: bit 2 watchdog, bit 1 external, bit 0 power-on |
| sts1 | output | 1 | Boot-failure cause flag |
| wdt_en | output | 1 | Watchdog reset enable |
| core_rst | output | 1 | Core reset, active high |
| gpio_hiz | output | 1 | Forces all other general-purpose pins to high impedance |
| pin_a_mode | output | 2 | Handshake pin A drive: 00 high-Z, 01 resistive low, 10 strong high |
| pin_b_mode | output | 2 | Handshake pin B drive, same coding |
| phase | output | 3 | 0 run, 1/2 power-on phases, 3 external hold, 4 external tail, 5 short hold |

## Verification
The hardest situation to reach is a request arriving mid-sequence, because the synchronizer delays the external input by two cycles. The bench has to place its edges knowing that delay. The stimulus drops the external input, waits until the tail phase is showing, then raises the input again. It checks that the hold phase returns and that a clear written during the hold loses to the flag being set again. A separate cycle-exact count from the end of power-on confirms the boundary between the two 256-cycle phases. Simultaneous power-on and boot-failure requests confirm the priority.

// File: rtl/rsq_pkg.sv
// Shared types for the reset sequencer.
// Assumes: phase codes and drive codes are seen at the top-level ports.
package rsq_pkg;

    localparam int PH_W  = 3;
    localparam int DRV_W = 2;

    typedef enum logic [PH_W-1:0] {
        PH_RUN      = 3'd0,
        PH_PWR_A    = 3'd1,
        PH_PWR_B    = 3'd2,
        PH_EXT_HOLD = 3'd3,
        PH_EXT_TAIL = 3'd4,
        PH_SHORT    = 3'd5
    } phase_e;

    localparam logic [DRV_W-1:0] DRV_HIZ   = 2'b00;
    localparam logic [DRV_W-1:0] DRV_RLOW  = 2'b01;
    localparam logic [DRV_W-1:0] DRV_SHIGH = 2'b10;

endpackage

// File: rtl/rsq_sync.sv
// Multi-flop synchronizer bringing an asynchronous level into the sleep clock.
// Assumes: the input is a slow level. Output is low after reset.
module rsq_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_async,
    output logic q_sync
);

    logic [STAGES-1:0] chain;

    // Shift the asynchronous level through the flop chain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chain <= '0;
        end else begin
            chain <= {chain[STAGES-2:0], d_async};
        end
    end

    assign q_sync = chain[STAGES-1];

endmodule

// File: rtl/rsq_seq_fsm.sv
// Phase sequencer: chooses the winning reset source and times each phase.
// Assumes: request inputs are already in the clk domain.
// Priority is power-on, external, watchdog, boot failure.
module rsq_seq_fsm
    import rsq_pkg::*;
#(
    parameter int PWR_CYC   = 256,
    parameter int TAIL_CYC  = 8,
    parameter int SHORT_CYC = 8
) (
    input  logic   clk,
    input  logic   rst_n,
    input  logic   pwr_take,
    input  logic   ext_level,
    input  logic   wdt_take,
    input  logic   boot_take,
    output phase_e phase_q
);

    localparam int MAX_A = (PWR_CYC > TAIL_CYC) ? PWR_CYC : TAIL_CYC;
    localparam int MAX_C = (MAX_A > SHORT_CYC) ? MAX_A : SHORT_CYC;
    localparam int CNT_W = (MAX_C > 2) ? $clog2(MAX_C) : 1;

    localparam logic [CNT_W-1:0] PWR_LAST   = CNT_W'(PWR_CYC - 1);
    localparam logic [CNT_W-1:0] TAIL_LAST  = CNT_W'(TAIL_CYC - 1);
    localparam logic [CNT_W-1:0] SHORT_LAST = CNT_W'(SHORT_CYC - 1);

    phase_e           ph_d;
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] cnt_d;

    // Next phase and counter: requests restart a phase, otherwise phases run out.
    always_comb begin
        ph_d  = phase_q;
        cnt_d = cnt_q + 1'b1;
        if (pwr_take) begin
            ph_d  = PH_PWR_A;
            cnt_d = '0;
        end else if (ext_level) begin
            ph_d  = PH_EXT_HOLD;
            cnt_d = '0;
        end else if (wdt_take || boot_take) begin
            ph_d  = PH_SHORT;
            cnt_d = '0;
        end else begin
            case (phase_q)
                PH_PWR_A: if (cnt_q == PWR_LAST) begin
                    ph_d  = PH_PWR_B;
                    cnt_d = '0;
                end
                PH_PWR_B: if (cnt_q == PWR_LAST) begin
                    ph_d  = PH_RUN;
                    cnt_d = '0;
                end
                PH_EXT_HOLD: begin
                    ph_d  = PH_EXT_TAIL;
                    cnt_d = '0;
                end
                PH_EXT_TAIL: if (cnt_q == TAIL_LAST) begin
                    ph_d  = PH_RUN;
                    cnt_d = '0;
                end
                PH_SHORT: if (cnt_q == SHORT_LAST) begin
                    ph_d  = PH_RUN;
                    cnt_d = '0;
                end
                default: begin
                    ph_d  = PH_RUN;
                    cnt_d = '0;
                end
            endcase
        end
    end

    // Phase and counter registers, entering the first power-on phase at reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q <= PH_PWR_A;
            cnt_q   <= '0;
        end else begin
            phase_q <= ph_d;
            cnt_q   <= cnt_d;
        end
    end

endmodule

// File: rtl/rsq_cause_log.sv
// Sticky reset-cause flags with write-1-to-clear, plus the watchdog enable.
// Assumes: at most one win_* input is high per cycle (the top enforces priority).
module rsq_cause_log (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       win_pwr,
    input  logic       win_ext,
    input  logic       win_wdt,
    input  logic       win_boot,
    input  logic       any_take,
    input  logic [2:0] clr0,
    input  logic       clr1,
    input  logic       en_wr,
    input  logic       en_wdata,
    output logic [2:0] sts0_q,
    output logic       sts1_q,
    output logic       wdt_en_q
);

    // Cause flags: power-on overwrites everything; otherwise a set wins over a clear.
    always_ff @(posedge clk) begin
        if (!rst_n || win_pwr) begin
            sts0_q <= 3'b001;
            sts1_q <= 1'b0;
        end else begin
            sts0_q <= (sts0_q & ~clr0) | {win_wdt, win_ext, 1'b0};
            sts1_q <= (sts1_q & ~clr1) | win_boot;
        end
    end

    // Watchdog enable: defaults off and drops whenever any reset is taken.
    always_ff @(posedge clk) begin
        if (!rst_n || any_take) begin
            wdt_en_q <= 1'b0;
        end else if (en_wr) begin
            wdt_en_q <= en_wdata;
        end
    end

endmodule

// File: rtl/reset_sequencer.sv
// Chip-level reset sequencer on the sleep clock.
// Synchronizes the external reset, arbitrates sources, times the release
// phases, decodes the handshake pin drive modes and keeps the cause flags.
// Assumes: the sleep clock runs whenever any reset source may be active.
module reset_sequencer #(
    parameter int PWR_CYC     = 256,
    parameter int TAIL_CYC    = 8,
    parameter int SHORT_CYC   = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       por_req,
    input  logic       ext_rst_in,
    input  logic       wdt_expire,
    input  logic       wdt_en_wr,
    input  logic       wdt_en_wdata,
    input  logic       boot_fail,
    input  logic [2:0] sts0_clr,
    input  logic       sts1_clr,
    output logic [2:0] sts0,
    output logic       sts1,
    output logic       wdt_en,
    output logic       core_rst,
    output logic       gpio_hiz,
    output logic [1:0] pin_a_mode,
    output logic [1:0] pin_b_mode,
    output logic [2:0] phase
);

    import rsq_pkg::*;

    logic   ext_sync;
    logic   wdt_take;
    logic   win_pwr, win_ext, win_wdt, win_boot;
    phase_e ph;

    rsq_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .d_async (ext_rst_in),
        .q_sync  (ext_sync)
    );

    // Source arbitration: one winner per cycle, in fixed priority.
    always_comb begin
        wdt_take = wdt_expire && wdt_en;
        win_pwr  = por_req;
        win_ext  = !por_req && ext_sync;
        win_wdt  = !por_req && !ext_sync && wdt_take;
        win_boot = !por_req && !ext_sync && !wdt_take && boot_fail;
    end

    rsq_seq_fsm #(
        .PWR_CYC   (PWR_CYC),
        .TAIL_CYC  (TAIL_CYC),
        .SHORT_CYC (SHORT_CYC)
    ) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .pwr_take  (por_req),
        .ext_level (ext_sync),
        .wdt_take  (wdt_take),
        .boot_take (boot_fail),
        .phase_q   (ph)
    );

    rsq_cause_log u_cause (
        .clk      (clk),
        .rst_n    (rst_n),
        .win_pwr  (win_pwr),
        .win_ext  (win_ext),
        .win_wdt  (win_wdt),
        .win_boot (win_boot),
        .any_take (win_pwr || win_ext || win_wdt || win_boot),
        .clr0     (sts0_clr),
        .clr1     (sts1_clr),
        .en_wr    (wdt_en_wr),
        .en_wdata (wdt_en_wdata),
        .sts0_q   (sts0),
        .sts1_q   (sts1),
        .wdt_en_q (wdt_en)
    );

    // Drive-mode decode for the two handshake pins, per phase.
    always_comb begin
        pin_a_mode = DRV_HIZ;
        pin_b_mode = DRV_HIZ;
        case (ph)
            PH_PWR_A: begin
                pin_a_mode = DRV_SHIGH;
                pin_b_mode = DRV_RLOW;
            end
            PH_PWR_B, PH_EXT_HOLD, PH_EXT_TAIL: begin
                pin_a_mode = DRV_RLOW;
                pin_b_mode = DRV_RLOW;
            end
            default: begin
                pin_a_mode = DRV_HIZ;
                pin_b_mode = DRV_HIZ;
            end
        endcase
    end

    // Core reset and general pin tri-state follow every non-run phase.
    always_comb begin
        core_rst = (ph != PH_RUN);
        gpio_hiz = (ph != PH_RUN);
        phase    = ph;
    end

endmodule

// File: rtl/reset_sequencer_chk.sv
// Assertion checker for reset_sequencer, attached by bind below.
// Assumes: rst_n is low from time zero until the first edges have passed.
module reset_sequencer_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       por_req,
    input logic       ext_sync,
    input logic       wdt_expire,
    input logic       boot_fail,
    input logic [2:0] sts0_clr,
    input logic [2:0] sts0,
    input logic       sts1,
    input logic       wdt_en,
    input logic       core_rst,
    input logic       gpio_hiz,
    input logic [1:0] pin_a_mode,
    input logic [1:0] pin_b_mode,
    input logic [2:0] phase
);

    AST_A_HIGH_ONLY_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
        (pin_a_mode == 2'b10) |-> (phase == 3'd1 && pin_b_mode == 2'b01)); // R2

    AST_RUN_PINS_HIZ: assert property (@(posedge clk) disable iff (!rst_n)
        !core_rst |-> (pin_a_mode == 2'b00 && pin_b_mode == 2'b00 && !gpio_hiz)); // R3

    AST_RELEASE_FROM_END: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(core_rst) |-> ($past(phase) == 3'd2 || $past(phase) == 3'd4 || $past(phase) == 3'd5)); // R3

    AST_EXT_PINS_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == 3'd3 || phase == 3'd4) |-> (pin_a_mode == 2'b01 && pin_b_mode == 2'b01)); // R4

    AST_WDT_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (wdt_expire && !wdt_en && !por_req && !ext_sync && !boot_fail && !core_rst) |=> !core_rst); // R5

    AST_WDT_EN_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(core_rst) |-> !wdt_en); // R5

    AST_SHORT_PINS_HIZ: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == 3'd5) |-> (pin_a_mode == 2'b00 && pin_b_mode == 2'b00 && core_rst)); // R6

    AST_EXT_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (sts0[1] && !sts0_clr[1] && !por_req) |=> sts0[1]); // R7

    AST_PWR_FLAGS_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        por_req |=> (sts0 == 3'b001 && !sts1)); // R9

    AST_EXT_OVER_LOWER: assert property (@(posedge clk) disable iff (!rst_n)
        (ext_sync && !por_req) |=> (phase == 3'd3)); // R10

endmodule

bind reset_sequencer reset_sequencer_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .por_req    (por_req),
    .ext_sync   (ext_sync),
    .wdt_expire (wdt_expire),
    .boot_fail  (boot_fail),
    .sts0_clr   (sts0_clr),
    .sts0       (sts0),
    .sts1       (sts1),
    .wdt_en     (wdt_en),
    .core_rst   (core_rst),
    .gpio_hiz   (gpio_hiz),
    .pin_a_mode (pin_a_mode),
    .pin_b_mode (pin_b_mode),
    .phase      (phase)
);

// File: tb/sim_reset_sequencer.sv
`timescale 1ns/1ps
// Self-checking bench: a vector table of reset sources, then directed cases.
module sim_reset_sequencer;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       por_req = 1'b0;
    logic       ext_rst_in = 1'b0;
    logic       wdt_expire = 1'b0;
    logic       wdt_en_wr = 1'b0;
    logic       wdt_en_wdata = 1'b0;
    logic       boot_fail = 1'b0;
    logic [2:0] sts0_clr = 3'b000;
    logic       sts1_clr = 1'b0;
    logic [2:0] sts0;
    logic       sts1;
    logic       wdt_en;
    logic       core_rst;
    logic       gpio_hiz;
    logic [1:0] pin_a_mode;
    logic [1:0] pin_b_mode;
    logic [2:0] phase;

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    reset_sequencer u0 (
        .clk(clk), .rst_n(rst_n), .por_req(por_req), .ext_rst_in(ext_rst_in),
        .wdt_expire(wdt_expire), .wdt_en_wr(wdt_en_wr), .wdt_en_wdata(wdt_en_wdata),
        .boot_fail(boot_fail), .sts0_clr(sts0_clr), .sts1_clr(sts1_clr),
        .sts0(sts0), .sts1(sts1), .wdt_en(wdt_en), .core_rst(core_rst),
        .gpio_hiz(gpio_hiz), .pin_a_mode(pin_a_mode), .pin_b_mode(pin_b_mode),
        .phase(phase)
    );

    // Vector: kind[19:18] (0 pwr,1 ext,2 wdt,3 boot), edges to release[17:8],
    // sts0[7:5], sts1[4], pin A at first edge[3:2], pin B at first edge[1:0].
    localparam int NVEC = 5;
    localparam logic [19:0] VEC [NVEC] = '{
        {2'd0, 10'd512, 3'b001, 1'b0, 2'b10, 2'b01},
        {2'd1, 10'd11,  3'b011, 1'b0, 2'b01, 2'b01},
        {2'd2, 10'd8,   3'b111, 1'b0, 2'b00, 2'b00},
        {2'd3, 10'd8,   3'b111, 1'b1, 2'b00, 2'b00},
        {2'd0, 10'd512, 3'b001, 1'b0, 2'b10, 2'b01}
    };

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic trig_pwr();
        @(negedge clk) por_req = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk) por_req = 1'b0;
    endtask

    task automatic trig_ext();
        @(negedge clk) ext_rst_in = 1'b1;
        repeat (5) @(posedge clk);
        @(negedge clk) ext_rst_in = 1'b0;
    endtask

    task automatic write_en(input logic v);
        @(negedge clk) begin wdt_en_wr = 1'b1; wdt_en_wdata = v; end
        @(negedge clk) wdt_en_wr = 1'b0;
    endtask

    task automatic trig_wdt();
        write_en(1'b1);
        wdt_expire = 1'b1;
        @(negedge clk) wdt_expire = 1'b0;
    endtask

    task automatic trig_boot();
        @(negedge clk) boot_fail = 1'b1;
        @(negedge clk) boot_fail = 1'b0;
    endtask

    // Count edges until core_rst drops; records pin modes after the first edge.
    task automatic count_release(output int n, output logic [1:0] pa, output logic [1:0] pb);
        n = 0; pa = 2'b11; pb = 2'b11;
        do begin
            @(posedge clk); #1;
            n++;
            if (n == 1) begin pa = pin_a_mode; pb = pin_b_mode; end
        end while (core_rst && n < 2000);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        int n;
        logic [1:0] pa, pb;

        // R1: reset state
        repeat (4) @(posedge clk); #1;
        chk("R1 core_rst", core_rst, 1);
        chk("R1 gpio_hiz", gpio_hiz, 1);
        chk("R1 phase", phase, 1);
        chk("R1 sts0", sts0, 3'b001);
        chk("R1 sts1", sts1, 0);
        chk("R1 wdt_en", wdt_en, 0);
        chk("R2 pin A reset", pin_a_mode, 2'b10);
        chk("R2 pin B reset", pin_b_mode, 2'b01);

        // R2/R3: exact phase boundaries after reset release
        @(negedge clk) rst_n = 1'b1;
        repeat (255) @(posedge clk); #1;
        chk("R2 phase at edge 255", phase, 1);
        @(posedge clk); #1;
        chk("R3 phase at edge 256", phase, 2);
        chk("R3 pin A second phase", pin_a_mode, 2'b01);
        chk("R3 pin B second phase", pin_b_mode, 2'b01);
        repeat (255) @(posedge clk); #1;
        chk("R3 still held at edge 511", core_rst, 1);
        @(posedge clk); #1;
        chk("R3 phase at edge 512", phase, 0);
        chk("R3 core released", core_rst, 0);
        chk("R3 pin A hiz", pin_a_mode, 2'b00);
        chk("R3 pin B hiz", pin_b_mode, 2'b00);
        chk("R1 gpio_hiz released", gpio_hiz, 0);

        // Table walk: R2 R4 R6 R7 R9 per source
        for (int i = 0; i < NVEC; i++) begin
            case (VEC[i][19:18])
                2'd0: trig_pwr();
                2'd1: trig_ext();
                2'd2: trig_wdt();
                default: trig_boot();
            endcase
            count_release(n, pa, pb);
            chk("R2/R4/R6 release edges", n, int'(VEC[i][17:8]));
            chk("R7/R9 sts0", sts0, VEC[i][7:5]);
            chk("R7/R9 sts1", sts1, VEC[i][4]);
            chk("R2/R4/R6 pin A", pa, VEC[i][3:2]);
            chk("R2/R4/R6 pin B", pb, VEC[i][1:0]);
            chk("R5 wdt_en dropped", wdt_en, 0);
        end

        // R8: write-1-to-clear touches only the written bits
        trig_ext();
        count_release(n, pa, pb);
        chk("R7 ext flag set", sts0, 3'b011);
        @(negedge clk) sts0_clr = 3'b001;
        @(negedge clk) sts0_clr = 3'b000;
        chk("R8 clear bit0 only", sts0, 3'b010);
        trig_boot();
        count_release(n, pa, pb);
        chk("R7 boot flag set", sts1, 1);
        chk("R7 ext flag kept", sts0, 3'b010);
        @(negedge clk) sts1_clr = 1'b1;
        @(negedge clk) sts1_clr = 1'b0;
        chk("R8 clear sts1", sts1, 0);

        // R5: watchdog expiry ignored with enable off
        @(negedge clk) wdt_expire = 1'b1;
        @(negedge clk) wdt_expire = 1'b0;
        @(posedge clk); #1;
        chk("R5 ignored core_rst", core_rst, 0);
        chk("R5 ignored sts0", sts0, 3'b010);

        // R5: enable written, then dropped by a boot-failure reset
        write_en(1'b1);
        chk("R5 enable written", wdt_en, 1);
        trig_boot();
        count_release(n, pa, pb);
        chk("R6 boot hold edges", n, 8);
        chk("R5 enable cleared by reset", wdt_en, 0);

        // R10/R4: external request during the tail restarts the hold
        @(negedge clk) ext_rst_in = 1'b1;
        repeat (5) @(posedge clk);
        @(negedge clk) ext_rst_in = 1'b0;
        repeat (4) @(posedge clk); #1;
        chk("R4 tail phase", phase, 4);
        @(negedge clk) ext_rst_in = 1'b1;
        repeat (3) @(posedge clk); #1;
        chk("R10 restart to hold", phase, 3);
        chk("R10 core held", core_rst, 1);
        @(negedge clk) sts0_clr = 3'b010;
        @(negedge clk) sts0_clr = 3'b000;
        chk("R8 set wins over clear", sts0[1], 1);
        @(negedge clk) ext_rst_in = 1'b0;
        count_release(n, pa, pb);
        chk("R4 release after restart", n, 11);

        // R10: power-on beats a simultaneous boot failure
        @(negedge clk) begin por_req = 1'b1; boot_fail = 1'b1; end
        @(negedge clk) begin por_req = 1'b0; boot_fail = 1'b0; end
        #1;
        chk("R10 power-on wins phase", phase, 1);
        count_release(n, pa, pb);
        chk("R10 power-on release edges", n, 512);
        chk("R10 boot flag not set", sts1, 0);
        chk("R9 only power-on flag", sts0, 3'b001);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule